// File: doc/BRIEF.md
# Scattered Vector Register Field Decoder

This block takes a 128-bit wide-issue instruction bundle together with a requested format number and slot number. It gathers the vector register indices that the chosen slot encodes. Each 5-bit index is not contiguous in the bundle. Its low bits sit near the slot's nominal offset and its upper bits come from distant, unrelated positions, so every field is a fixed gather of individual bundle bits. The block also checks that the bundle really carries the requested format before it trusts any field.

Three index latches form the primary set, used by the main vector ALU slot and the multiply slot. A separate set of three latches serves the second ALU slot of the five-slot format. A 2-bit sub-operation latch serves the multiply slot of format 0. The primary latches are called A, B and C. In formats 0 to 2 they carry the target, source and result register roles. Format 3 permutes that assignment, and the decoder reproduces the permutation exactly. A request is taken through a valid/ready handshake. The decoded result appears one cycle later with a valid strobe. Rejected requests leave every latch untouched.

Top module: `vreg_field_decoder`

## Requirements
- R1: Format 0, slot 3 writes the primary set: A gets bundle bits {36,37,38,50,51}, B gets {39,40,75,76,77} and C gets {56,45,46,47,48}. Each list runs from index bit 0 upward.
- R2: Formats 1 and 2, slot 3 write the primary set: A gets bundle bits {31,33,34,50,51}, B gets {36,37,38,39,40} and C gets {56,46,47,48,49}.
- R3: Format 3, slot 3 writes the primary set with the format's own role order: A gets {79,33,52,50,53}, B gets {56,46,47,48,49} and C gets {36,37,38,39,40}.
- R4: Format 3, slot 4 writes only the secondary set: secondary A gets {81,82,83,97,98}, secondary B gets {60,61,62,63,72}, and secondary C gets {54,55,57,59} in bits 3..0 with bit 4 forced to 0.
- R5: Format 0, slot 2 (multiply) writes only the sub-operation latch, taking bundle bits 28 (LSB) and 29.
- R6: Format 1, slot 2 (multiply) writes the primary set: A gets {70..74}, B gets {41..45} and C gets {64..68}.
- R7: A bundle carries a format when bits [3:0] are 0xF and bits [25:24] hold the format code: 1 for format 0, 2 for format 1, 3 for format 2 and 0 for format 3. Bit 26 is ignored, so format 0 matches byte-3 low bits 1 or 5. If the bundle does not match the requested format, the request is consumed, out_valid stays low and every latch keeps its value.
- R8: Any other format/slot pair is consumed without effect: out_valid stays low and every latch keeps its value. This covers slots 0, 1 and 5 to 7, slot 4 outside format 3, and slot 2 in formats 2 and 3.
- R9: A decode accepted at a clock edge shows out_valid and its latch values right after that edge. out_valid stays high with stable outputs while out_ready is low, and in_ready is low exactly while out_valid is high and out_ready is low.
- R10: After reset, out_valid is 0, in_ready is 1, out_kind is 0 and all latches read 0.
- R11: out_kind tells which set the last successful decode wrote: 0 for primary, 1 for secondary, 2 for sub-operation. A decode leaves the latches of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| bundle | input | 128 | Instruction bundle |
| fmt_sel | input | 2 | Requested format 0..3 |
| slot_sel | input | 3 | Requested slot 0..7 |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Decoded result present |
| out_kind | output | 2 | Latch set written by the last decode |
| pri_a | output | 5 | Primary latch A |
| pri_b | output | 5 | Primary latch B |
| pri_c | output | 5 | Primary latch C |
| sec_a | output | 5 | Secondary latch A |
| sec_b | output | 5 | Secondary latch B |
| sec_c | output | 5 | Secondary latch C |
| sub_op | output | 2 | Sub-operation selector |

## Verification
Every decode result is due one edge after acceptance, because a single register stage sits between the handshake and the latches. The bench drives each request on a falling edge. It lets one rising edge take the request and compares all outputs at the next falling edge. For a rejected request, that same sample must show out_valid low and every latch equal to the bench's own model of the last good decode. Under back-pressure the bench holds a request for two edges while in_ready is low, checks that nothing has moved, then releases out_ready. It expects the new result one edge later and expects out_valid to clear one edge after that.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam int BUNDLE_W = 128;
  localparam int IDX_W    = 5;
  localparam int POS_W    = $clog2(BUNDLE_W);
  localparam int SUB_W    = 2;
  localparam int LATCH_N  = 3;
  localparam int KIND_W   = 2;
  localparam int FMT_W    = 2;
  localparam int SLOT_W   = 3;

  localparam logic [KIND_W-1:0] KIND_PRI = 2'd0;
  localparam logic [KIND_W-1:0] KIND_SEC = 2'd1;
  localparam logic [KIND_W-1:0] KIND_SUB = 2'd2;

  // gather table entries
  localparam int G_F0_A  = 0;
  localparam int G_F0_B  = 1;
  localparam int G_F0_C  = 2;
  localparam int G_F12_A = 3;
  localparam int G_F12_B = 4;
  localparam int G_F12_C = 5;
  localparam int G_F3_A  = 6;
  localparam int G_F3_B  = 7;
  localparam int G_F3_C  = 8;
  localparam int G_D_A   = 9;
  localparam int G_D_B   = 10;
  localparam int G_D_C   = 11;
  localparam int G_M1_A  = 12;
  localparam int G_M1_B  = 13;
  localparam int G_M1_C  = 14;
  localparam int G_M0_S  = 15;
  localparam int NFIELD  = 16;

  typedef logic [IDX_W*POS_W-1:0] pos_list_t;
  typedef logic [IDX_W-1:0]       idx_t;
  typedef idx_t [LATCH_N-1:0]     idx_set_t;

  function automatic pos_list_t pk(input int b0, input int b1, input int b2,
                                   input int b3, input int b4);
    pos_list_t r;
    r = '0;
    r[0*POS_W +: POS_W] = POS_W'(b0);
    r[1*POS_W +: POS_W] = POS_W'(b1);
    r[2*POS_W +: POS_W] = POS_W'(b2);
    r[3*POS_W +: POS_W] = POS_W'(b3);
    r[4*POS_W +: POS_W] = POS_W'(b4);
    return r;
  endfunction

  // positions listed from index bit 0 upward
  localparam pos_list_t FIELD_POS [NFIELD] = '{
    pk(36, 37, 38, 50, 51),
    pk(39, 40, 75, 76, 77),
    pk(56, 45, 46, 47, 48),
    pk(31, 33, 34, 50, 51),
    pk(36, 37, 38, 39, 40),
    pk(56, 46, 47, 48, 49),
    pk(79, 33, 52, 50, 53),
    pk(56, 46, 47, 48, 49),
    pk(36, 37, 38, 39, 40),
    pk(81, 82, 83, 97, 98),
    pk(60, 61, 62, 63, 72),
    pk(54, 55, 57, 59, 0),
    pk(70, 71, 72, 73, 74),
    pk(41, 42, 43, 44, 45),
    pk(64, 65, 66, 67, 68),
    pk(28, 29, 0, 0, 0)
  };

  localparam int FIELD_NB [NFIELD] = '{
    5, 5, 5, 5, 5, 5, 5, 5, 5, 5, 5, 4, 5, 5, 5, 2
  };

endpackage

// File: rtl/vfd_trigger.sv
module vfd_trigger
  import vfd_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle,
  input  logic [FMT_W-1:0]    fmt_sel,
  output logic                fmt_match
);
  localparam logic [3:0] SEL_NIBBLE = 4'hF;

  logic             nib_ok;
  logic [FMT_W-1:0] want_code;

  // format code in bits [25:24] is the format number plus one, modulo four
  always_comb begin
    nib_ok    = (bundle[3:0] == SEL_NIBBLE);
    want_code = fmt_sel + FMT_W'(1);
    fmt_match = nib_ok && (bundle[25:24] == want_code);
  end

endmodule

// File: rtl/vfd_gather.sv
module vfd_gather
  import vfd_pkg::*;
#(
  parameter int        NB  = IDX_W,
  parameter pos_list_t POS = '0
) (
  input  logic [BUNDLE_W-1:0] bundle,
  output logic [IDX_W-1:0]    idx
);
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    if (b < NB) begin : g_take
      localparam logic [POS_W-1:0] P = POS[b*POS_W +: POS_W];
      assign idx[b] = bundle[P];
    end else begin : g_zero
      assign idx[b] = 1'b0;
    end
  end

endmodule

// File: rtl/vfd_route.sv
module vfd_route
  import vfd_pkg::*;
(
  input  logic [FMT_W-1:0]         fmt_sel,
  input  logic [SLOT_W-1:0]        slot_sel,
  input  idx_t [NFIELD-1:0]        fields,
  output logic                     supported,
  output logic                     wr_pri,
  output logic                     wr_sec,
  output logic                     wr_sub,
  output logic [KIND_W-1:0]        kind,
  output idx_set_t                 pri_nxt,
  output idx_set_t                 sec_nxt,
  output logic [SUB_W-1:0]         sub_nxt
);
  logic [IDX_W-SUB_W-1:0] unused_sub_hi;

  always_comb begin
    supported     = 1'b0;
    wr_pri        = 1'b0;
    wr_sec        = 1'b0;
    wr_sub        = 1'b0;
    kind          = KIND_PRI;
    pri_nxt       = '0;
    sec_nxt       = '0;
    sub_nxt       = fields[G_M0_S][SUB_W-1:0];
    unused_sub_hi = fields[G_M0_S][IDX_W-1:SUB_W];
    unique case (slot_sel)
      3'd3: begin
        supported = 1'b1;
        wr_pri    = 1'b1;
        kind      = KIND_PRI;
        unique case (fmt_sel)
          2'd0:      pri_nxt = {fields[G_F0_C],  fields[G_F0_B],  fields[G_F0_A]};
          2'd1, 2'd2: pri_nxt = {fields[G_F12_C], fields[G_F12_B], fields[G_F12_A]};
          default:   pri_nxt = {fields[G_F3_C],  fields[G_F3_B],  fields[G_F3_A]};
        endcase
      end
      3'd4: begin
        if (fmt_sel == 2'd3) begin
          supported = 1'b1;
          wr_sec    = 1'b1;
          kind      = KIND_SEC;
          sec_nxt   = {fields[G_D_C], fields[G_D_B], fields[G_D_A]};
        end
      end
      3'd2: begin
        if (fmt_sel == 2'd0) begin
          supported = 1'b1;
          wr_sub    = 1'b1;
          kind      = KIND_SUB;
        end else if (fmt_sel == 2'd1) begin
          supported = 1'b1;
          wr_pri    = 1'b1;
          kind      = KIND_PRI;
          pri_nxt   = {fields[G_M1_C], fields[G_M1_B], fields[G_M1_A]};
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vreg_field_decoder.sv
module vreg_field_decoder
  import vfd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUNDLE_W-1:0]  bundle,
  input  logic [FMT_W-1:0]     fmt_sel,
  input  logic [SLOT_W-1:0]    slot_sel,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [KIND_W-1:0]    out_kind,
  output logic [IDX_W-1:0]     pri_a,
  output logic [IDX_W-1:0]     pri_b,
  output logic [IDX_W-1:0]     pri_c,
  output logic [IDX_W-1:0]     sec_a,
  output logic [IDX_W-1:0]     sec_b,
  output logic [IDX_W-1:0]     sec_c,
  output logic [SUB_W-1:0]     sub_op
);
  // reset synchronizer: async assert, sync release
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // field gather
  idx_t [NFIELD-1:0] fields;

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    vfd_gather #(
      .NB  (FIELD_NB[f]),
      .POS (FIELD_POS[f])
    ) i_gather (
      .bundle (bundle),
      .idx    (fields[f])
    );
  end

  logic fmt_match;

  vfd_trigger i_trigger (
    .bundle    (bundle),
    .fmt_sel   (fmt_sel),
    .fmt_match (fmt_match)
  );

  logic              supported, wr_pri, wr_sec, wr_sub;
  logic [KIND_W-1:0] kind_d;
  idx_set_t          pri_d, sec_d;
  logic [SUB_W-1:0]  sub_d;

  vfd_route i_route (
    .fmt_sel   (fmt_sel),
    .slot_sel  (slot_sel),
    .fields    (fields),
    .supported (supported),
    .wr_pri    (wr_pri),
    .wr_sec    (wr_sec),
    .wr_sub    (wr_sub),
    .kind      (kind_d),
    .pri_nxt   (pri_d),
    .sec_nxt   (sec_d),
    .sub_nxt   (sub_d)
  );

  // state
  logic              vld_q, vld_nxt;
  logic [KIND_W-1:0] kind_q;
  idx_set_t          pri_q, sec_q;
  logic [SUB_W-1:0]  sub_q;

  logic accept, good, en_pri, en_sec, en_sub, en_kind;

  always_comb begin
    in_ready = rst_q_n && (!vld_q || out_ready);
    accept   = in_valid && in_ready;
    good     = accept && fmt_match && supported;
    en_pri   = good && wr_pri;
    en_sec   = good && wr_sec;
    en_sub   = good && wr_sub;
    en_kind  = good;
    if (accept)         vld_nxt = good;
    else if (out_ready) vld_nxt = 1'b0;
    else                vld_nxt = vld_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      kind_q <= KIND_PRI;
      pri_q  <= '0;
      sec_q  <= '0;
      sub_q  <= '0;
    end else begin
      vld_q <= vld_nxt;
      if (en_kind) kind_q <= kind_d;
      if (en_pri)  pri_q  <= pri_d;
      if (en_sec)  sec_q  <= sec_d;
      if (en_sub)  sub_q  <= sub_d;
    end
  end

  assign out_valid = vld_q;
  assign out_kind  = kind_q;
  assign pri_a     = pri_q[0];
  assign pri_b     = pri_q[1];
  assign pri_c     = pri_q[2];
  assign sec_a     = sec_q[0];
  assign sec_b     = sec_q[1];
  assign sec_c     = sec_q[2];
  assign sub_op    = sub_q;

  // bundle bits no field reads
  logic unused_bundle;
  assign unused_bundle = ^bundle;

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker
  import vfd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [BUNDLE_W-1:0] bundle,
  input logic [FMT_W-1:0]    fmt_sel,
  input logic [SLOT_W-1:0]   slot_sel,
  input logic                out_ready,
  input logic                out_valid,
  input logic [KIND_W-1:0]   out_kind,
  input logic [IDX_W-1:0]    pri_a,
  input logic [IDX_W-1:0]    pri_b,
  input logic [IDX_W-1:0]    pri_c,
  input logic [IDX_W-1:0]    sec_a,
  input logic [IDX_W-1:0]    sec_b,
  input logic [IDX_W-1:0]    sec_c,
  input logic [SUB_W-1:0]    sub_op
);
  logic acc;
  logic [3*IDX_W-1:0] pri_all, sec_all;
  assign acc     = in_valid && in_ready;
  assign pri_all = {pri_c, pri_b, pri_a};
  assign sec_all = {sec_c, sec_b, sec_a};

  assert_rise_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pri_all) && $stable(sec_all)
                                && $stable(sub_op) && $stable(out_kind));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_idle_keeps_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(pri_all) && $stable(sec_all) && $stable(sub_op));

  assert_bad_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bundle[3:0] != 4'hF |=> !out_valid && $stable(pri_all)
                                   && $stable(sec_all) && $stable(sub_op));

  assert_bad_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (slot_sel < 3'd2 || slot_sel > 3'd4) |=> !out_valid && $stable(pri_all)
                                                    && $stable(sec_all) && $stable(sub_op));

  assert_sec_only_dual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot_sel != 3'd4 |=> $stable(sec_all));

  assert_kind_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_kind != 2'd3);

  assert_subop_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot_sel == 3'd2 && fmt_sel == 2'd0 && bundle[3:0] == 4'hF
    && bundle[25:24] == 2'd1 |=> out_valid && sub_op == $past(bundle[29:28]));

  assert_f0_alu_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot_sel == 3'd3 && fmt_sel == 2'd0 && bundle[3:0] == 4'hF
    && bundle[25:24] == 2'd1 |=> out_valid
    && pri_a == $past({bundle[51], bundle[50], bundle[38], bundle[37], bundle[36]}));

endmodule

bind vreg_field_decoder vfd_checker i_vfd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .bundle    (bundle),
  .fmt_sel   (fmt_sel),
  .slot_sel  (slot_sel),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .pri_a     (pri_a),
  .pri_b     (pri_b),
  .pri_c     (pri_c),
  .sec_a     (sec_a),
  .sec_b     (sec_b),
  .sec_c     (sec_c),
  .sub_op    (sub_op)
);

// File: tb/test_vreg_field_decoder.sv
`timescale 1ns/100ps
module test_vreg_field_decoder;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] bundle = '0;
  logic [1:0]   fmt_sel = '0;
  logic [2:0]   slot_sel = '0;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [1:0]   out_kind;
  logic [4:0]   pri_a, pri_b, pri_c, sec_a, sec_b, sec_c;
  logic [1:0]   sub_op;

  always #2.5 clk = ~clk;

  vreg_field_decoder i_vreg_field_decoder (
    .clk, .rst_n, .in_valid, .in_ready, .bundle, .fmt_sel, .slot_sel,
    .out_ready, .out_valid, .out_kind, .pri_a, .pri_b, .pri_c,
    .sec_a, .sec_b, .sec_c, .sub_op
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the latches
  logic [4:0] ep [3];
  logic [4:0] es [3];
  logic [1:0] esub;
  logic [1:0] ekind;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input bit exp_valid);
    chk(req, "out_valid", out_valid, exp_valid);
    chk(req, "pri_a", pri_a, ep[0]);
    chk(req, "pri_b", pri_b, ep[1]);
    chk(req, "pri_c", pri_c, ep[2]);
    chk(req, "sec_a", sec_a, es[0]);
    chk(req, "sec_b", sec_b, es[1]);
    chk(req, "sec_c", sec_c, es[2]);
    chk(req, "sub_op", sub_op, esub);
    chk(req, "out_kind", out_kind, ekind);
  endtask

  function automatic logic [127:0] put(input logic [127:0] b, input int p0, input int p1,
                                       input int p2, input int p3, input int p4,
                                       input logic [4:0] v);
    logic [127:0] r;
    r = b;
    r[p0] = v[0];
    if (p1 >= 0) r[p1] = v[1];
    if (p2 >= 0) r[p2] = v[2];
    if (p3 >= 0) r[p3] = v[3];
    if (p4 >= 0) r[p4] = v[4];
    return r;
  endfunction

  function automatic logic [127:0] mk(input logic [1:0] code);
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    r[3:0]   = 4'hF;
    r[25:24] = code;
    return r;
  endfunction

  // drive on a falling edge, wait for acceptance, sample at the next falling edge
  task automatic send(input logic [127:0] b, input logic [1:0] f, input logic [2:0] s);
    @(negedge clk);
    bundle = b; fmt_sel = f; slot_sel = s; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10", "in_ready", in_ready, 1);
    chk_all("R10", 1'b0);
  endtask

  task automatic t_f0_alu;
    for (int i = 0; i < 4; i++) begin
      logic [4:0] a, b, c;
      logic [127:0] bb;
      a = (i == 0) ? 5'd31 : 5'($urandom);
      b = (i == 0) ? 5'd0  : 5'($urandom);
      c = (i == 0) ? 5'd21 : 5'($urandom);
      bb = mk(2'd1);
      bb[26] = i[0];                       // R7: byte-3 low bits 1 and 5
      bb = put(bb, 36, 37, 38, 50, 51, a);
      bb = put(bb, 39, 40, 75, 76, 77, b);
      bb = put(bb, 56, 45, 46, 47, 48, c);
      send(bb, 2'd0, 3'd3);
      ep[0] = a; ep[1] = b; ep[2] = c; ekind = 2'd0;
      chk_all("R1", 1'b1);
    end
  endtask

  task automatic t_f12_alu;
    for (int i = 0; i < 4; i++) begin
      logic [4:0] a, b, c;
      logic [127:0] bb;
      logic [1:0] f;
      f = (i < 2) ? 2'd1 : 2'd2;
      a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
      bb = mk(f + 2'd1);
      bb = put(bb, 31, 33, 34, 50, 51, a);
      bb = put(bb, 36, 37, 38, 39, 40, b);
      bb = put(bb, 56, 46, 47, 48, 49, c);
      send(bb, f, 3'd3);
      ep[0] = a; ep[1] = b; ep[2] = c; ekind = 2'd0;
      chk_all("R2", 1'b1);
    end
  endtask

  task automatic t_f3_alu;
    for (int i = 0; i < 3; i++) begin
      logic [4:0] a, b, c;
      logic [127:0] bb;
      a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
      bb = mk(2'd0);
      bb = put(bb, 79, 33, 52, 50, 53, a);
      bb = put(bb, 56, 46, 47, 48, 49, b);
      bb = put(bb, 36, 37, 38, 39, 40, c);
      send(bb, 2'd3, 3'd3);
      ep[0] = a; ep[1] = b; ep[2] = c; ekind = 2'd0;
      chk_all("R3", 1'b1);
    end
  endtask

  task automatic t_f3_dual;
    for (int i = 0; i < 3; i++) begin
      logic [4:0] a, b, c;
      logic [127:0] bb;
      a = 5'($urandom); b = 5'($urandom); c = (i == 0) ? 5'd31 : 5'($urandom);
      bb = mk(2'd0);
      bb = put(bb, 81, 82, 83, 97, 98, a);
      bb = put(bb, 60, 61, 62, 63, 72, b);
      bb = put(bb, 54, 55, 57, 59, -1, c);
      send(bb, 2'd3, 3'd4);
      es[0] = a; es[1] = b; es[2] = {1'b0, c[3:0]}; ekind = 2'd1;
      chk_all("R4", 1'b1);               // also R11: primary untouched
    end
  endtask

  task automatic t_f0_mul;
    for (int i = 0; i < 4; i++) begin
      logic [127:0] bb;
      bb = mk(2'd1);
      bb[28] = i[0]; bb[29] = i[1];
      send(bb, 2'd0, 3'd2);
      esub = i[1:0]; ekind = 2'd2;
      chk_all("R5", 1'b1);               // also R11: other sets unchanged
    end
  endtask

  task automatic t_f1_mul;
    for (int i = 0; i < 3; i++) begin
      logic [4:0] a, b, c;
      logic [127:0] bb;
      a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
      bb = mk(2'd2);
      bb = put(bb, 70, 71, 72, 73, 74, a);
      bb = put(bb, 41, 42, 43, 44, 45, b);
      bb = put(bb, 64, 65, 66, 67, 68, c);
      send(bb, 2'd1, 3'd2);
      ep[0] = a; ep[1] = b; ep[2] = c; ekind = 2'd0;
      chk_all("R6", 1'b1);
    end
  endtask

  task automatic t_trigger;
    logic [127:0] bb;
    // format 0 bundle requested as format 1
    bb = mk(2'd1);
    send(bb, 2'd1, 3'd3);
    chk_all("R7", 1'b0);
    // wrong selector nibble
    bb = mk(2'd1); bb[3:0] = 4'hE;
    send(bb, 2'd0, 3'd3);
    chk_all("R7", 1'b0);
    // format 3 code presented for format 3 dual slot but nibble wrong
    bb = mk(2'd0); bb[3:0] = 4'h7;
    send(bb, 2'd3, 3'd4);
    chk_all("R7", 1'b0);
    // format 2 bundle requested as format 0 multiply
    bb = mk(2'd3);
    send(bb, 2'd0, 3'd2);
    chk_all("R7", 1'b0);
  endtask

  task automatic t_unsupported;
    send(mk(2'd1), 2'd0, 3'd0);  chk_all("R8", 1'b0);
    send(mk(2'd2), 2'd1, 3'd1);  chk_all("R8", 1'b0);
    send(mk(2'd1), 2'd0, 3'd4);  chk_all("R8", 1'b0);
    send(mk(2'd3), 2'd2, 3'd2);  chk_all("R8", 1'b0);
    send(mk(2'd0), 2'd3, 3'd2);  chk_all("R8", 1'b0);
    send(mk(2'd0), 2'd3, 3'd5);  chk_all("R8", 1'b0);
  endtask

  task automatic t_backpressure;
    logic [127:0] ba, bb;
    logic [4:0] a1, a2;
    a1 = 5'd9; a2 = 5'd22;
    ba = mk(2'd1);
    ba = put(ba, 36, 37, 38, 50, 51, a1);
    ba = put(ba, 39, 40, 75, 76, 77, 5'd1);
    ba = put(ba, 56, 45, 46, 47, 48, 5'd2);
    bb = mk(2'd2);
    bb = put(bb, 31, 33, 34, 50, 51, a2);
    bb = put(bb, 36, 37, 38, 39, 40, 5'd3);
    bb = put(bb, 56, 46, 47, 48, 49, 5'd4);
    @(negedge clk);
    out_ready = 1'b0;
    send(ba, 2'd0, 3'd3);
    ep[0] = a1; ep[1] = 5'd1; ep[2] = 5'd2; ekind = 2'd0;
    chk_all("R9", 1'b1);
    chk("R9", "in_ready stalled", in_ready, 0);
    bundle = bb; fmt_sel = 2'd1; slot_sel = 3'd3; in_valid = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk_all("R9", 1'b1);                 // still first result, request held off
    out_ready = 1'b1;
    #1;
    chk("R9", "in_ready released", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ep[0] = a2; ep[1] = 5'd3; ep[2] = 5'd4;
    chk_all("R9", 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk_all("R9", 1'b0);
  endtask

  initial begin
    ep[0] = '0; ep[1] = '0; ep[2] = '0;
    es[0] = '0; es[1] = '0; es[2] = '0;
    esub = '0; ekind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_f0_alu();
    t_f12_alu();
    t_f3_alu();
    t_f3_dual();
    t_f0_mul();
    t_f1_mul();
    t_trigger();
    t_unsupported();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule